// File: doc/BRIEF.md
# Condition Code Flag Unit

This block holds the 8-bit condition-code register of a small microcontroller core, together with the core's 16-bit D register. D is split into a high accumulator A and a low accumulator B. The arithmetic datapath sits outside this block. On each operation it hands over an operation class, an operand width, both operands and the result it produced. From these the unit derives the negative, zero, overflow and carry flags and stores them on the next clock edge.

Carry and overflow are taken from the sign bits of the operands and the result, not from the adder's carry-out. The datapath therefore only has to deliver the result word. For shifts, the datapath also supplies the bit that was shifted out.

Software-visible control uses three mechanisms:
- A whole-register load.
- A per-bit set mask.
- A per-bit clear mask.

The accumulator halves can each be written alone without disturbing the other half.

Register layout, bit 7 down to bit 0: S, X, H, I, N, Z, V, C.

Top module: `ccu_top`

## Requirements
- R1: A synchronous reset sets the register to 8'h50 (X at bit 6 and I at bit 4 set, every other flag clear) and sets D to zero.
- R2: On an add (op_class 0), C is the top bit of (a&b)|(b&~r)|(a&~r) and V is the top bit of (a&b&~r)|(~a&~b&r). The top bit is bit 7 when op_wide is 0 and bit 15 when op_wide is 1.
- R3: On a subtract (op_class 1), C is the top bit of (~a&b)|(b&r)|(~a&r) and V is the top bit of (a&~b&~r)|(~a&b&r).
- R4: For every operation class, N (bit 3) equals the top bit of the result. Z (bit 2) is 1 exactly when the low 8 bits of the result are zero (op_wide 0) or all 16 bits are zero (op_wide 1). Upper operand bits have no effect in 8-bit mode.
- R5: On a shift (op_class 2), C (bit 0) takes shift_cout and V (bit 1) becomes N XOR the new C.
- R6: On a test (op_class 3), V is cleared and C keeps its previous value.
- R7: Operations never change S, X, H or I (bits 7, 6, 5, 4). Only a load or the set and clear masks change them.
- R8: A 1 in bit_set forces that flag to 1 and a 1 in bit_clr forces it to 0, clear winning over set. Other bits are untouched. Both masks apply after any operation update in the same cycle.
- R9: ccr_load replaces the whole register with ccr_load_val and overrides an operation or mask in the same cycle.
- R10: Flags change only on a clock edge where op_valid, ccr_load or a mask bit is active. Otherwise the register holds.
- R11: a_wr writes D[15:8] and b_wr writes D[7:0], each leaving the other half intact. d_wr writes all 16 bits and takes priority over a_wr and b_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_class | input | 2 | 0 add, 1 subtract, 2 shift, 3 test |
| op_wide | input | 1 | 1 for 16-bit operation, 0 for 8-bit |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| op_res | input | 16 | Result from the datapath |
| shift_cout | input | 1 | Bit shifted out on a shift |
| ccr_load | input | 1 | Whole-register load strobe |
| ccr_load_val | input | 8 | Value for the load |
| bit_set | input | 8 | Per-flag set mask |
| bit_clr | input | 8 | Per-flag clear mask |
| ccr | output | 8 | Condition-code register |
| a_wr | input | 1 | Write accumulator A |
| a_data | input | 8 | Data for A |
| b_wr | input | 1 | Write accumulator B |
| b_data | input | 8 | Data for B |
| d_wr | input | 1 | Write whole D |
| d_data | input | 16 | Data for D |
| d_q | output | 16 | D register (A in 15:8, B in 7:0) |

## Verification
The properties assume three things about the inputs:
- Reset is held from time zero until at least one edge has passed.
- Every control input carries a known value after reset.
- The strobes of one cycle may overlap freely.

The shift property needs nothing of the result: N XOR C must hold in the register whatever op_res and shift_cout are. The stimulus keeps to these conditions by driving every input to a defined idle value from the first instant. It changes inputs only on falling edges and deliberately overlaps a load with an operation and masks to exercise the priority order.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

    localparam int CCR_W  = 8;
    localparam int DATA_W = 16;

    localparam int POS_C = 0;
    localparam int POS_V = 1;
    localparam int POS_Z = 2;
    localparam int POS_N = 3;
    localparam int POS_I = 4;
    localparam int POS_H = 5;
    localparam int POS_X = 6;
    localparam int POS_S = 7;

    localparam logic [CCR_W-1:0] CCR_RESET = (CCR_W'(1) << POS_X) | (CCR_W'(1) << POS_I);
    localparam logic [CCR_W-1:0] CTRL_MASK = (CCR_W'(1) << POS_S) | (CCR_W'(1) << POS_X)
                                           | (CCR_W'(1) << POS_H) | (CCR_W'(1) << POS_I);

    typedef enum logic [1:0] {
        CC_ADD   = 2'd0,
        CC_SUB   = 2'd1,
        CC_SHIFT = 2'd2,
        CC_TEST  = 2'd3
    } cc_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } arith_flags_t;

    function automatic logic [CCR_W-1:0] merge_arith(input logic [CCR_W-1:0] cur,
                                                     input arith_flags_t f);
        logic [CCR_W-1:0] r;
        r        = cur;
        r[POS_N] = f.n;
        r[POS_Z] = f.z;
        r[POS_V] = f.v;
        r[POS_C] = f.c;
        return r;
    endfunction

endpackage

// File: rtl/ccu_flag_eval.sv
module ccu_flag_eval
    import ccu_pkg::*;
#(
    parameter int WORD_W = DATA_W
) (
    input  logic [1:0]        op_class,
    input  logic              op_wide,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [WORD_W-1:0] op_res,
    input  logic              shift_cout,
    input  logic              cur_c,
    output arith_flags_t      flags
);
    localparam int HALF_W = WORD_W / 2;
    localparam int IDX_W  = $clog2(WORD_W);

    logic [WORD_W-1:0] add_c_vec;
    logic [WORD_W-1:0] add_v_vec;
    logic [WORD_W-1:0] sub_c_vec;
    logic [WORD_W-1:0] sub_v_vec;
    logic [IDX_W-1:0]  top_idx;
    logic              res_top;
    logic              res_zero;
    cc_op_e            op_kind;

    assign op_kind   = cc_op_e'(op_class);
    assign add_c_vec = (op_a & op_b) | (op_b & ~op_res) | (op_a & ~op_res);
    assign add_v_vec = (op_a & op_b & ~op_res) | (~op_a & ~op_b & op_res);
    assign sub_c_vec = (~op_a & op_b) | (op_b & op_res) | (~op_a & op_res);
    assign sub_v_vec = (op_a & ~op_b & ~op_res) | (~op_a & op_b & op_res);

    assign top_idx  = op_wide ? IDX_W'(WORD_W - 1) : IDX_W'(HALF_W - 1);
    assign res_top  = op_res[top_idx];
    assign res_zero = op_wide ? (op_res == '0) : (op_res[HALF_W-1:0] == '0);

    always_comb begin
        flags.n = res_top;
        flags.z = res_zero;
        flags.v = 1'b0;
        flags.c = cur_c;
        case (op_kind)
            CC_ADD: begin
                flags.c = add_c_vec[top_idx];
                flags.v = add_v_vec[top_idx];
            end
            CC_SUB: begin
                flags.c = sub_c_vec[top_idx];
                flags.v = sub_v_vec[top_idx];
            end
            CC_SHIFT: begin
                flags.c = shift_cout;
                flags.v = res_top ^ shift_cout;
            end
            default: begin
                flags.c = cur_c;
                flags.v = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ccu_ccr_reg.sv
module ccu_ccr_reg
    import ccu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  arith_flags_t     flags,
    input  logic             ccr_load,
    input  logic [CCR_W-1:0] ccr_load_val,
    input  logic [CCR_W-1:0] bit_set,
    input  logic [CCR_W-1:0] bit_clr,
    output logic [CCR_W-1:0] ccr_q
);
    logic [CCR_W-1:0] after_op;
    logic [CCR_W-1:0] after_mask;

    always_comb begin
        after_op = op_valid ? merge_arith(ccr_q, flags) : ccr_q;
    end

    for (genvar k = 0; k < CCR_W; k++) begin : g_bit
        assign after_mask[k] = bit_clr[k] ? 1'b0 : (bit_set[k] ? 1'b1 : after_op[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ccr_q <= CCR_RESET;
        end else if (ccr_load) begin
            ccr_q <= ccr_load_val;
        end else begin
            ccr_q <= after_mask;
        end
    end

endmodule

// File: rtl/ccu_dreg.sv
module ccu_dreg
    import ccu_pkg::*;
#(
    parameter int WORD_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_wr,
    input  logic [WORD_W/2-1:0] a_data,
    input  logic              b_wr,
    input  logic [WORD_W/2-1:0] b_data,
    input  logic              d_wr,
    input  logic [WORD_W-1:0] d_data,
    output logic [WORD_W-1:0] d_q
);
    localparam int HALF_W = WORD_W / 2;
    localparam int N_HALF = 2;

    for (genvar g = 0; g < N_HALF; g++) begin : g_half
        logic              half_en;
        logic [HALF_W-1:0] half_val;
        logic [HALF_W-1:0] half_q;

        if (g == 1) begin : g_hi
            assign half_en  = d_wr | a_wr;
            assign half_val = d_wr ? d_data[WORD_W-1:HALF_W] : a_data;
        end else begin : g_lo
            assign half_en  = d_wr | b_wr;
            assign half_val = d_wr ? d_data[HALF_W-1:0] : b_data;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                half_q <= '0;
            end else if (half_en) begin
                half_q <= half_val;
            end
        end

        assign d_q[g*HALF_W +: HALF_W] = half_q;
    end

endmodule

// File: rtl/ccu_top.sv
module ccu_top
    import ccu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [1:0]  op_class,
    input  logic        op_wide,
    input  logic [15:0] op_a,
    input  logic [15:0] op_b,
    input  logic [15:0] op_res,
    input  logic        shift_cout,
    input  logic        ccr_load,
    input  logic [7:0]  ccr_load_val,
    input  logic [7:0]  bit_set,
    input  logic [7:0]  bit_clr,
    output logic [7:0]  ccr,
    input  logic        a_wr,
    input  logic [7:0]  a_data,
    input  logic        b_wr,
    input  logic [7:0]  b_data,
    input  logic        d_wr,
    input  logic [15:0] d_data,
    output logic [15:0] d_q
);
    arith_flags_t     new_flags;
    logic [CCR_W-1:0] ccr_q;

    ccu_flag_eval #(.WORD_W(DATA_W)) u_eval (
        .op_class   (op_class),
        .op_wide    (op_wide),
        .op_a       (op_a),
        .op_b       (op_b),
        .op_res     (op_res),
        .shift_cout (shift_cout),
        .cur_c      (ccr_q[POS_C]),
        .flags      (new_flags)
    );

    ccu_ccr_reg u_ccr (
        .clk          (clk),
        .rst          (rst),
        .op_valid     (op_valid),
        .flags        (new_flags),
        .ccr_load     (ccr_load),
        .ccr_load_val (ccr_load_val),
        .bit_set      (bit_set),
        .bit_clr      (bit_clr),
        .ccr_q        (ccr_q)
    );

    ccu_dreg #(.WORD_W(DATA_W)) u_dreg (
        .clk    (clk),
        .rst    (rst),
        .a_wr   (a_wr),
        .a_data (a_data),
        .b_wr   (b_wr),
        .b_data (b_data),
        .d_wr   (d_wr),
        .d_data (d_data),
        .d_q    (d_q)
    );

    assign ccr = ccr_q;

endmodule

// File: rtl/ccu_top_chk.sv
module ccu_top_chk
    import ccu_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [1:0]  op_class,
    input logic        ccr_load,
    input logic [7:0]  ccr_load_val,
    input logic [7:0]  bit_set,
    input logic [7:0]  bit_clr,
    input logic [7:0]  ccr,
    input logic        a_wr,
    input logic        b_wr,
    input logic        d_wr,
    input logic [15:0] d_q
);
    logic started = 1'b0;
    logic quiet;

    always_ff @(posedge clk) started <= 1'b1;

    assign quiet = !ccr_load && (bit_set == '0) && (bit_clr == '0);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        started && rst |=> (ccr == CCR_RESET) && (d_q == '0));

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid && quiet |=> $stable(ccr));

    // R6
    test_flags_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && (op_class == 2'd3) && quiet
        |=> (ccr[POS_V] == 1'b0) && (ccr[POS_C] == $past(ccr[POS_C])));

    // R5
    shift_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && (op_class == 2'd2) && quiet
        |=> ccr[POS_V] == (ccr[POS_N] ^ ccr[POS_C]));

    // R7
    ctrl_bits_kept_chk: assert property (@(posedge clk) disable iff (rst)
        !ccr_load && (((bit_set | bit_clr) & CTRL_MASK) == '0)
        |=> (ccr & CTRL_MASK) == ($past(ccr) & CTRL_MASK));

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        !ccr_load && (bit_clr != '0) |=> (ccr & $past(bit_clr)) == '0);

    // R9
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        ccr_load |=> ccr == $past(ccr_load_val));

    // R11
    a_keeps_b_chk: assert property (@(posedge clk) disable iff (rst)
        a_wr && !b_wr && !d_wr |=> d_q[7:0] == $past(d_q[7:0]));

    // R11
    b_keeps_a_chk: assert property (@(posedge clk) disable iff (rst)
        b_wr && !a_wr && !d_wr |=> d_q[15:8] == $past(d_q[15:8]));

endmodule

bind ccu_top ccu_top_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .op_valid     (op_valid),
    .op_class     (op_class),
    .ccr_load     (ccr_load),
    .ccr_load_val (ccr_load_val),
    .bit_set      (bit_set),
    .bit_clr      (bit_clr),
    .ccr          (ccr),
    .a_wr         (a_wr),
    .b_wr         (b_wr),
    .d_wr         (d_wr),
    .d_q          (d_q)
);

// File: tb/ccu_top_bench.sv
`timescale 1ns/1ps
module ccu_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_class = 2'd0;
    logic        op_wide = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [15:0] op_res = '0;
    logic        shift_cout = 1'b0;
    logic        ccr_load = 1'b0;
    logic [7:0]  ccr_load_val = '0;
    logic [7:0]  bit_set = '0;
    logic [7:0]  bit_clr = '0;
    logic [7:0]  ccr;
    logic        a_wr = 1'b0;
    logic [7:0]  a_data = '0;
    logic        b_wr = 1'b0;
    logic [7:0]  b_data = '0;
    logic        d_wr = 1'b0;
    logic [15:0] d_data = '0;
    logic [15:0] d_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0]  m_ccr = 8'h50;
    logic [15:0] m_d   = '0;
    logic [7:0]  exp_ccr_q[$];
    logic [15:0] exp_d_q[$];
    string       exp_tag_q[$];

    ccu_top u_ccu_top (.*);

    always #4 clk = ~clk;

    task automatic idle();
        op_valid = 1'b0; ccr_load = 1'b0; bit_set = '0; bit_clr = '0;
        a_wr = 1'b0; b_wr = 1'b0; d_wr = 1'b0; shift_cout = 1'b0;
    endtask

    task automatic push_model(input string tag);
        logic [15:0] msk;
        logic [16:0] sum;
        logic sa, sb, sr, c, v;
        msk = op_wide ? 16'hFFFF : 16'h00FF;
        sa  = op_wide ? op_a[15] : op_a[7];
        sb  = op_wide ? op_b[15] : op_b[7];
        sr  = op_wide ? op_res[15] : op_res[7];
        if (ccr_load) begin
            m_ccr = ccr_load_val;
        end else begin
            if (op_valid) begin
                c = m_ccr[0];
                v = 1'b0;
                case (op_class)
                    2'd0: begin
                        sum = {1'b0, op_a & msk} + {1'b0, op_b & msk};
                        c = op_wide ? sum[16] : sum[8];
                        v = (sa == sb) && (sr != sa);
                    end
                    2'd1: begin
                        c = (op_a & msk) < (op_b & msk);
                        v = (sa != sb) && (sr != sa);
                    end
                    2'd2: begin
                        c = shift_cout;
                        v = sr ^ shift_cout;
                    end
                    default: begin
                        v = 1'b0;
                    end
                endcase
                m_ccr[3] = sr;
                m_ccr[2] = ((op_res & msk) == 16'h0);
                m_ccr[1] = v;
                m_ccr[0] = c;
            end
            m_ccr = (m_ccr | bit_set) & ~bit_clr;
        end
        if (d_wr) m_d = d_data;
        else begin
            if (a_wr) m_d[15:8] = a_data;
            if (b_wr) m_d[7:0]  = b_data;
        end
        exp_ccr_q.push_back(m_ccr);
        exp_d_q.push_back(m_d);
        exp_tag_q.push_back(tag);
    endtask

    task automatic do_op(input logic [1:0] cls, input logic wide,
                         input logic [15:0] a, input logic [15:0] b, input string tag);
        @(negedge clk);
        idle();
        op_valid = 1'b1; op_class = cls; op_wide = wide; op_a = a; op_b = b;
        case (cls)
            2'd0: op_res = a + b;
            2'd1: op_res = a - b;
            2'd2: begin
                shift_cout = wide ? a[15] : a[7];
                op_res = a << 1;
            end
            default: op_res = a;
        endcase
        push_model(tag);
    endtask

    task automatic do_ctl(input logic ld, input logic [7:0] lv, input logic [7:0] s,
                          input logic [7:0] cl, input logic with_op, input string tag);
        @(negedge clk);
        idle();
        ccr_load = ld; ccr_load_val = lv; bit_set = s; bit_clr = cl;
        if (with_op) begin
            op_valid = 1'b1; op_class = 2'd0; op_wide = 1'b0;
            op_a = 16'h00FF; op_b = 16'h0001; op_res = 16'h0100;
        end
        push_model(tag);
    endtask

    task automatic do_dw(input logic aw, input logic bw, input logic dw,
                         input logic [15:0] val, input string tag);
        @(negedge clk);
        idle();
        a_wr = aw; b_wr = bw; d_wr = dw;
        a_data = val[15:8] ^ 8'h11; b_data = val[7:0] ^ 8'h22; d_data = val;
        push_model(tag);
    endtask

    task automatic do_idle(input string tag);
        @(negedge clk);
        idle();
        op_class = 2'd0; op_a = 16'hFFFF; op_b = 16'hFFFF; op_res = 16'h0000;
        push_model(tag);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #2;
            if (exp_ccr_q.size() > 0) begin
                logic [7:0]  ec;
                logic [15:0] ed;
                string       tg;
                ec = exp_ccr_q.pop_front();
                ed = exp_d_q.pop_front();
                tg = exp_tag_q.pop_front();
                checks++;
                if (ccr !== ec || d_q !== ed) begin
                    fails++;
                    $display("FAIL %s: ccr=%h d=%h, expected ccr=%h d=%h", tg, ccr, d_q, ec, ed);
                end
            end
        end
    end

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        checks++;
        if (ccr !== 8'h50 || d_q !== 16'h0000) begin
            fails++;
            $display("FAIL R1 reset: ccr=%h d=%h, expected ccr=50 d=0000", ccr, d_q);
        end
        rst = 1'b0;

        do_op(2'd0, 1'b0, 16'hAB7F, 16'hCD01, "R2 add8 signed overflow");
        do_op(2'd0, 1'b0, 16'h12FF, 16'h3401, "R2 R4 add8 carry to zero");
        do_op(2'd0, 1'b1, 16'h8000, 16'h8000, "R2 add16 carry and overflow");
        do_op(2'd0, 1'b1, 16'h1234, 16'h0001, "R2 add16 plain");
        do_op(2'd1, 1'b0, 16'h5500, 16'h0001, "R3 sub8 borrow");
        do_op(2'd1, 1'b0, 16'h0080, 16'h0001, "R3 sub8 overflow");
        do_op(2'd1, 1'b1, 16'h5000, 16'h5000, "R3 R4 sub16 zero");
        do_op(2'd1, 1'b1, 16'h7FFF, 16'hFFFF, "R3 sub16 borrow overflow");
        do_op(2'd2, 1'b0, 16'h00C0, 16'h0000, "R5 shift8 carry out");
        do_op(2'd2, 1'b0, 16'hFF40, 16'h0000, "R5 R4 shift8 sign change");
        do_op(2'd2, 1'b1, 16'h8000, 16'h0000, "R5 shift16 to zero");
        do_op(2'd3, 1'b1, 16'h8000, 16'h0000, "R6 test16 keeps carry");
        do_op(2'd3, 1'b0, 16'hFF00, 16'h0000, "R6 R4 test8 zero low byte");
        do_idle("R10 idle no strobe");
        do_ctl(1'b0, 8'h00, 8'hA0, 8'h10, 1'b0, "R8 set S H clear I");
        do_op(2'd1, 1'b0, 16'h0000, 16'h0001, "R7 op keeps S X H I");
        do_ctl(1'b0, 8'h00, 8'h03, 8'h01, 1'b0, "R8 clear wins over set");
        do_ctl(1'b0, 8'h00, 8'h04, 8'h02, 1'b1, "R8 masks after op");
        do_ctl(1'b1, 8'hA5, 8'h5A, 8'h0F, 1'b1, "R9 load overrides all");
        do_idle("R10 hold after load");
        do_dw(1'b0, 1'b0, 1'b1, 16'h1234, "R11 write D");
        do_dw(1'b1, 1'b0, 1'b0, 16'hBA00, "R11 write A keeps B");
        do_dw(1'b0, 1'b1, 1'b0, 16'h00EF, "R11 write B keeps A");
        do_dw(1'b1, 1'b1, 1'b0, 16'h5566, "R11 write A and B");
        do_dw(1'b1, 1'b1, 1'b1, 16'h9ABC, "R11 D has priority");
        do_idle("R10 final idle");
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule